// File: doc/BRIEF.md
# Dataflow Multi-Port Handshake Memory

This block is an on-chip register-array memory for elastic dataflow circuits. It has `NL` load ports and `NS` store ports, and every channel uses a valid/ready handshake. A load port takes an address token. It returns the addressed word on its data channel and a payload-free completion token on its done channel. A store port takes an address token and a data token together and writes the word. One cycle after the write it raises a payload-free completion token.

Reads are combinational with zero latency. Only the low `IDX_W = $clog2(DEPTH)` bits of each address select an entry; the upper bits are ignored. Port vectors are packed by port number: port `i` occupies bits `[i*W +: W]` of each packed bus, and bit `i` of each valid/ready bus.

Each load port runs a three-state fork machine:
- `FK_OPEN`: neither output has taken its token.
- `FK_DATA_TAKEN`: the data output took its token first.
- `FK_DONE_TAKEN`: the done output took its token first.

In `FK_OPEN`, a handshake on the data output alone moves the machine to `FK_DATA_TAKEN`, and a handshake on the done output alone moves it to `FK_DONE_TAKEN`. Any state returns to `FK_OPEN` when the address handshake completes.

Each store port runs a two-state machine:
- `ST_EMPTY`: no completion is pending.
- `ST_PENDING`: a completion token is waiting on the done output.

The port moves from `ST_EMPTY` to `ST_PENDING` on a write. In `ST_PENDING`, a done handshake either returns the port to `ST_EMPTY` or, if a new write happens in the same cycle, keeps it in `ST_PENDING`. Without a done handshake, `ST_PENDING` holds.

Top module: `dfmem`

## Requirements
- R1: After synchronous reset `rst`, every store done valid is low, and every fork machine is in `FK_OPEN`: a load's data valid and done valid both equal its address valid.
- R2: A load port's data output carries, in the same cycle, the array entry selected by its address, taken from bits `[i*DW +: DW]` of `ld_data_o`.
- R3: A load port's data valid and done valid follow its address valid until that output has taken its token. After that, the output's valid stays low until the address is consumed. Address ready is high only in a cycle in which every output has taken, or is taking, its token.
- R4: Address bits above the low `IDX_W` bits have no effect on which entry is read or written.
- R5: A store writes its data on the clock edge where both store valids are high and the port can accept. The new word is readable from the next cycle.
- R6: A store's done valid goes high in the cycle after its write and stays high until done ready is seen high.
- R7: Store address ready and store data ready are equal. They are high only when both store valids are high and the port can accept. A port can accept when no completion is pending, or when the pending completion is taken in the same cycle.
- R8: When several store ports write the same entry on one edge, the highest-numbered port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr_valid_i | input | NL | Load address valid, one bit per port |
| ld_addr_i | input | NL*AW | Load addresses, packed by port |
| ld_addr_ready_o | output | NL | Load address ready |
| ld_data_valid_o | output | NL | Load data valid |
| ld_data_o | output | NL*DW | Load read data, packed by port |
| ld_data_ready_i | input | NL | Load data ready |
| ld_done_valid_o | output | NL | Load completion valid (no payload) |
| ld_done_ready_i | input | NL | Load completion ready |
| st_addr_valid_i | input | NS | Store address valid |
| st_addr_i | input | NS*AW | Store addresses, packed by port |
| st_addr_ready_o | output | NS | Store address ready |
| st_data_valid_i | input | NS | Store data valid |
| st_data_i | input | NS*DW | Store data, packed by port |
| st_data_ready_o | output | NS | Store data ready |
| st_done_valid_o | output | NS | Store completion valid (no payload) |
| st_done_ready_i | input | NS | Store completion ready |

## Verification
The fork-hold assertions assume that a producer keeps a load address valid, and its address, stable until the address is accepted. The store assertions assume the same of the store address and data channels. The stimulus follows this rule on every input channel: it raises or changes a valid only after the previous token on that channel was consumed, while ready inputs toggle freely. The array is never reset. The bench therefore fills every entry through a store port before any load is issued, so the read data is always defined.

// File: rtl/dfmem_pkg.sv
package dfmem_pkg;

    typedef enum logic [1:0] {
        FK_OPEN       = 2'd0,
        FK_DATA_TAKEN = 2'd1,
        FK_DONE_TAKEN = 2'd2
    } fork_state_e;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_PENDING = 1'b1
    } store_state_e;

endpackage

// File: rtl/dfmem_load_fork.sv
module dfmem_load_fork
    import dfmem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_valid,
    output logic addr_ready,
    output logic data_valid,
    input  logic data_ready,
    output logic done_valid,
    input  logic done_ready
);

    fork_state_e state_q, state_d;
    logic data_taken, done_taken;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FK_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        data_taken = (state_q == FK_DATA_TAKEN);
        done_taken = (state_q == FK_DONE_TAKEN);
        data_valid = addr_valid && !data_taken;
        done_valid = addr_valid && !done_taken;
        addr_ready = addr_valid && (data_taken || data_ready)
                                && (done_taken || done_ready);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FK_OPEN: begin
                if (addr_ready)
                    state_d = FK_OPEN;
                else if (data_valid && data_ready)
                    state_d = FK_DATA_TAKEN;
                else if (done_valid && done_ready)
                    state_d = FK_DONE_TAKEN;
            end
            FK_DATA_TAKEN: if (addr_ready) state_d = FK_OPEN;
            FK_DONE_TAKEN: if (addr_ready) state_d = FK_OPEN;
            default:       state_d = FK_OPEN;
        endcase
    end

endmodule

// File: rtl/dfmem_store_port.sv
module dfmem_store_port
    import dfmem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic addr_valid,
    input  logic data_valid,
    output logic in_ready,
    output logic wr_en,
    output logic done_valid,
    input  logic done_ready
);

    store_state_e state_q, state_d;
    logic can_accept;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        done_valid = (state_q == ST_PENDING);
        can_accept = !done_valid || done_ready;
        wr_en      = addr_valid && data_valid && can_accept;
        in_ready   = wr_en;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:   if (wr_en) state_d = ST_PENDING;
            ST_PENDING: if (done_ready) state_d = wr_en ? ST_PENDING : ST_EMPTY;
            default:    state_d = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/dfmem_array.sv
module dfmem_array #(
    parameter int NL    = 2,
    parameter int NS    = 2,
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic [NS-1:0]    wr_en,
    input  logic [NS*IW-1:0] wr_idx,
    input  logic [NS*DW-1:0] wr_data,
    input  logic [NL*IW-1:0] rd_idx,
    output logic [NL*DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    // Ascending port order: a later non-blocking write wins on a shared entry.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NS; p++) begin
            if (wr_en[p])
                mem_q[wr_idx[p*IW +: IW]] <= wr_data[p*DW +: DW];
        end
    end

    for (genvar r = 0; r < NL; r++) begin : g_rd
        assign rd_data[r*DW +: DW] = mem_q[rd_idx[r*IW +: IW]];
    end

endmodule

// File: rtl/dfmem.sv
module dfmem #(
    parameter int NL    = 2,
    parameter int NS    = 2,
    parameter int DW    = 8,
    parameter int AW    = 6,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NL-1:0]    ld_addr_valid_i,
    input  logic [NL*AW-1:0] ld_addr_i,
    output logic [NL-1:0]    ld_addr_ready_o,
    output logic [NL-1:0]    ld_data_valid_o,
    output logic [NL*DW-1:0] ld_data_o,
    input  logic [NL-1:0]    ld_data_ready_i,
    output logic [NL-1:0]    ld_done_valid_o,
    input  logic [NL-1:0]    ld_done_ready_i,
    input  logic [NS-1:0]    st_addr_valid_i,
    input  logic [NS*AW-1:0] st_addr_i,
    output logic [NS-1:0]    st_addr_ready_o,
    input  logic [NS-1:0]    st_data_valid_i,
    input  logic [NS*DW-1:0] st_data_i,
    output logic [NS-1:0]    st_data_ready_o,
    output logic [NS-1:0]    st_done_valid_o,
    input  logic [NS-1:0]    st_done_ready_i
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [NS-1:0]    wr_en;
    logic [NS-1:0]    st_in_ready;
    logic [NS*IW-1:0] wr_idx;
    logic [NL*IW-1:0] rd_idx;

    for (genvar l = 0; l < NL; l++) begin : g_ld
        assign rd_idx[l*IW +: IW] = IW'(ld_addr_i[l*AW +: AW]);

        dfmem_load_fork u_fork (
            .clk        (clk),
            .rst        (rst),
            .addr_valid (ld_addr_valid_i[l]),
            .addr_ready (ld_addr_ready_o[l]),
            .data_valid (ld_data_valid_o[l]),
            .data_ready (ld_data_ready_i[l]),
            .done_valid (ld_done_valid_o[l]),
            .done_ready (ld_done_ready_i[l])
        );
    end

    for (genvar s = 0; s < NS; s++) begin : g_st
        assign wr_idx[s*IW +: IW] = IW'(st_addr_i[s*AW +: AW]);

        dfmem_store_port u_port (
            .clk        (clk),
            .rst        (rst),
            .addr_valid (st_addr_valid_i[s]),
            .data_valid (st_data_valid_i[s]),
            .in_ready   (st_in_ready[s]),
            .wr_en      (wr_en[s]),
            .done_valid (st_done_valid_o[s]),
            .done_ready (st_done_ready_i[s])
        );
    end

    assign st_addr_ready_o = st_in_ready;
    assign st_data_ready_o = st_in_ready;

    dfmem_array #(
        .NL    (NL),
        .NS    (NS),
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (st_data_i),
        .rd_idx  (rd_idx),
        .rd_data (ld_data_o)
    );

endmodule

// File: rtl/dfmem_chk.sv
module dfmem_chk #(
    parameter int NL    = 2,
    parameter int NS    = 2,
    parameter int DW    = 8,
    parameter int AW    = 6,
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [NL-1:0]    ld_addr_valid_i,
    input logic [NL*AW-1:0] ld_addr_i,
    input logic [NL-1:0]    ld_addr_ready_o,
    input logic [NL-1:0]    ld_data_valid_o,
    input logic [NL*DW-1:0] ld_data_o,
    input logic [NL-1:0]    ld_data_ready_i,
    input logic [NL-1:0]    ld_done_valid_o,
    input logic [NL-1:0]    ld_done_ready_i,
    input logic [NS-1:0]    st_addr_valid_i,
    input logic [NS*AW-1:0] st_addr_i,
    input logic [NS-1:0]    st_addr_ready_o,
    input logic [NS-1:0]    st_data_valid_i,
    input logic [NS*DW-1:0] st_data_i,
    input logic [NS-1:0]    st_data_ready_o,
    input logic [NS-1:0]    st_done_valid_o,
    input logic [NS-1:0]    st_done_ready_i
);

    for (genvar l = 0; l < NL; l++) begin : g_ldc
        // R3
        ld_ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
            ld_addr_ready_o[l] |-> ld_addr_valid_i[l]);
        // R3
        ld_data_once_chk: assert property (@(posedge clk) disable iff (rst)
            (ld_data_valid_o[l] && ld_data_ready_i[l] && !ld_addr_ready_o[l])
            |=> !ld_data_valid_o[l]);
        // R3
        ld_done_once_chk: assert property (@(posedge clk) disable iff (rst)
            (ld_done_valid_o[l] && ld_done_ready_i[l] && !ld_addr_ready_o[l])
            |=> !ld_done_valid_o[l]);
    end

    for (genvar s = 0; s < NS; s++) begin : g_stc
        // R6
        st_done_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (st_done_valid_o[s] && !st_done_ready_i[s]) |=> st_done_valid_o[s]);
        // R6
        st_done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(st_done_valid_o[s]) |-> $past(st_addr_ready_o[s]));
        // R7
        st_join_chk: assert property (@(posedge clk) disable iff (rst)
            st_addr_ready_o[s] |-> (st_data_ready_o[s] && st_addr_valid_i[s]
                                    && st_data_valid_i[s]));
        // R7
        st_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
            (st_done_valid_o[s] && !st_done_ready_i[s]) |-> !st_addr_ready_o[s]);
    end

endmodule

bind dfmem dfmem_chk #(
    .NL(NL), .NS(NS), .DW(DW), .AW(AW), .DEPTH(DEPTH)
) chk_i (.*);

// File: tb/dfmem_tb_top.sv
`timescale 1ns/100ps
module dfmem_tb_top;

    localparam int NL = 2, NS = 2, DW = 8, AW = 6, DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NL-1:0]    ld_addr_valid_i = '0, ld_data_ready_i = '0, ld_done_ready_i = '0;
    logic [NL*AW-1:0] ld_addr_i = '0;
    logic [NS-1:0]    st_addr_valid_i = '0, st_data_valid_i = '0, st_done_ready_i = '0;
    logic [NS*AW-1:0] st_addr_i = '0;
    logic [NS*DW-1:0] st_data_i = '0;
    logic [NL-1:0]    ld_addr_ready_o, ld_data_valid_o, ld_done_valid_o;
    logic [NL*DW-1:0] ld_data_o;
    logic [NS-1:0]    st_addr_ready_o, st_data_ready_o, st_done_valid_o;

    dfmem #(.NL(NL), .NS(NS), .DW(DW), .AW(AW), .DEPTH(DEPTH)) dut_i (.*);

    int checks = 0, failures = 0;
    bit done_flag = 0;

    // Behavioural reference state
    int  mem_m [DEPTH];
    bit  pend_m [NS];
    bit  dtk_m [NL];
    bit  ntk_m [NL];
    bit  ar_exp [NL];
    bit  sr_exp [NS];

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic update_model();
        for (int s = 0; s < NS; s++) begin
            bit can, wv;
            can = !pend_m[s] || st_done_ready_i[s];
            wv  = st_addr_valid_i[s] && st_data_valid_i[s] && can;
            if (wv) mem_m[st_addr_i[s*AW +: AW] % DEPTH] = int'(st_data_i[s*DW +: DW]);
            if (can) pend_m[s] = wv;
        end
        for (int l = 0; l < NL; l++) begin
            if (ar_exp[l]) begin
                dtk_m[l] = 0; ntk_m[l] = 0;
            end else if (ld_addr_valid_i[l]) begin
                if (!dtk_m[l] && !ntk_m[l]) begin
                    if (ld_data_ready_i[l]) dtk_m[l] = 1;
                    else if (ld_done_ready_i[l]) ntk_m[l] = 1;
                end
            end
        end
    endtask

    task automatic compare();
        for (int l = 0; l < NL; l++) begin
            bit av, edv, env;
            av  = ld_addr_valid_i[l];
            edv = av && !dtk_m[l];
            env = av && !ntk_m[l];
            ar_exp[l] = av && (dtk_m[l] || ld_data_ready_i[l]) && (ntk_m[l] || ld_done_ready_i[l]);
            chk(ld_data_valid_o[l] == edv, "R3", "ld_data_valid", ld_data_valid_o[l], edv);
            chk(ld_done_valid_o[l] == env, "R3", "ld_done_valid", ld_done_valid_o[l], env);
            chk(ld_addr_ready_o[l] == ar_exp[l], "R3", "ld_addr_ready", ld_addr_ready_o[l], ar_exp[l]);
            if (av) begin
                int e;
                e = mem_m[ld_addr_i[l*AW +: AW] % DEPTH];
                chk(int'(ld_data_o[l*DW +: DW]) == e, "R2 R4 R5", "ld_data",
                    ld_data_o[l*DW +: DW], e);
            end
        end
        for (int s = 0; s < NS; s++) begin
            bit can;
            can = !pend_m[s] || st_done_ready_i[s];
            sr_exp[s] = can && st_addr_valid_i[s] && st_data_valid_i[s];
            chk(st_addr_ready_o[s] == sr_exp[s], "R7", "st_addr_ready", st_addr_ready_o[s], sr_exp[s]);
            chk(st_data_ready_o[s] == sr_exp[s], "R7", "st_data_ready", st_data_ready_o[s], sr_exp[s]);
            chk(st_done_valid_o[s] == pend_m[s], "R6", "st_done_valid", st_done_valid_o[s], pend_m[s]);
        end
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        update_model();
    endtask

    task automatic end_cycle();
        #1;
        compare();
    endtask

    task automatic drive_random();
        for (int l = 0; l < NL; l++) begin
            if (!(ld_addr_valid_i[l] && !ar_exp[l])) begin
                ld_addr_valid_i[l] = ($urandom_range(0, 1) == 1);
                ld_addr_i[l*AW +: AW] = AW'($urandom);
            end
            ld_data_ready_i[l] = ($urandom_range(0, 4) > 1);
            ld_done_ready_i[l] = ($urandom_range(0, 4) > 1);
        end
        for (int s = 0; s < NS; s++) begin
            if (!(st_addr_valid_i[s] && !sr_exp[s])) begin
                st_addr_valid_i[s] = ($urandom_range(0, 2) != 0);
                st_addr_i[s*AW +: AW] = AW'($urandom);
            end
            if (!(st_data_valid_i[s] && !sr_exp[s])) begin
                st_data_valid_i[s] = ($urandom_range(0, 2) != 0);
                st_data_i[s*DW +: DW] = DW'($urandom);
            end
            st_done_ready_i[s] = ($urandom_range(0, 4) > 1);
        end
    endtask

    initial begin : main
        int fill;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(st_done_valid_o == '0, "R1", "st_done_valid after reset", st_done_valid_o, 0);
        chk(ld_data_valid_o == '0 && ld_done_valid_o == '0, "R1", "ld valids after reset",
            {ld_data_valid_o, ld_done_valid_o}, 0);
        compare();

        // Fill every entry through store port 0
        fill = 0;
        st_done_ready_i = '1;
        while (fill < DEPTH) begin
            begin_cycle();
            if (st_addr_valid_i[0] && sr_exp[0]) fill++;
            if (fill < DEPTH) begin
                st_addr_valid_i[0] = 1'b1; st_data_valid_i[0] = 1'b1;
                st_addr_i[0 +: AW] = AW'(fill);
                st_data_i[0 +: DW] = DW'(fill * 7 + 3);
            end else begin
                st_addr_valid_i[0] = 1'b0; st_data_valid_i[0] = 1'b0;
            end
            end_cycle();
        end

        // R5: word written during fill is readable
        begin_cycle();
        ld_addr_valid_i = 2'b01; ld_addr_i[0 +: AW] = AW'(3);
        ld_data_ready_i = '1; ld_done_ready_i = '1;
        end_cycle();
        chk(ld_data_o[0 +: DW] == 8'd24, "R5", "filled word", ld_data_o[0 +: DW], 24);

        // R8 collision, R4 truncated address on port 1
        begin_cycle();
        ld_addr_valid_i = '0;
        st_addr_valid_i = 2'b11; st_data_valid_i = 2'b11; st_done_ready_i = 2'b11;
        st_addr_i = {AW'(5 + 16), AW'(5)};
        st_data_i = {8'hB2, 8'hA1};
        end_cycle();
        chk(st_addr_ready_o == 2'b11, "R7", "both stores accepted", st_addr_ready_o, 3);

        begin_cycle();
        st_addr_valid_i = '0; st_data_valid_i = '0; st_done_ready_i = '0;
        ld_addr_valid_i = 2'b01; ld_addr_i[0 +: AW] = AW'(5 + 32);
        end_cycle();
        chk(ld_data_o[0 +: DW] == 8'hB2, "R8", "collision winner", ld_data_o[0 +: DW], 8'hB2);
        chk(st_done_valid_o == 2'b11, "R6", "done after write", st_done_valid_o, 3);

        // R7 backpressure: pending done not taken blocks a new store
        begin_cycle();
        ld_addr_valid_i = '0;
        st_addr_valid_i = 2'b01; st_data_valid_i = 2'b01;
        st_addr_i[0 +: AW] = AW'(2); st_data_i[0 +: DW] = 8'h5C;
        end_cycle();
        chk(st_addr_ready_o[0] == 1'b0, "R7", "blocked while pending", st_addr_ready_o[0], 0);
        chk(st_done_valid_o[0] == 1'b1, "R6", "done held", st_done_valid_o[0], 1);

        begin_cycle();
        st_done_ready_i = 2'b01;
        end_cycle();
        chk(st_addr_ready_o[0] == 1'b1, "R7", "accept on same-cycle take", st_addr_ready_o[0], 1);

        // Random traffic against the reference model
        for (int c = 0; c < 4000; c++) begin
            begin_cycle();
            drive_random();
            end_cycle();
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule